// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block converts a 32-bit linear address into a physical address by reading two levels of translation entries from memory. A directory base input points at the first-level table. For each accepted request the walker reads one first-level entry, checks it, reads one second-level entry, checks that too, and returns either a physical address or a fault code. The faulting linear address is kept in a register until the next fault replaces it.

Memory is reached through a read port with a one-cycle request pulse and a response strobe that may come back any number of cycles later. Only one read is in flight at any time. When the translation-enable input is low at the moment a request is accepted, no memory is read and the linear address is returned unchanged.

The walk states are `ST_IDLE` (ready for a request), `ST_DIR` (first-level read and check), `ST_TBL` (second-level read and check), `ST_DONE` (one-cycle result) and `ST_FAULT` (one-cycle fault report). The transitions are: `ST_IDLE`→`ST_DIR` on a request with translation on; `ST_IDLE`→`ST_DONE` on a request with translation off; `ST_DIR`→`ST_TBL` on a response that passes the checks; `ST_DIR`→`ST_FAULT` on a response that fails; `ST_TBL`→`ST_DONE` on a passing response; `ST_TBL`→`ST_FAULT` on a failing one; `ST_DONE` and `ST_FAULT` always return to `ST_IDLE`.

Top module: `xlate_walker`

## Requirements
- R1: The first-level read address is `{dir_base[31:12], va[31:22], 2'b00}`; the second-level read address is `{entry1[31:12], va[21:12], 2'b00}`, where entry1 is the first-level entry returned.
- R2: A successful translation returns `rsp_phys = {entry2[31:12], va[11:0]}` with `rsp_fault` = 0 and `rsp_code` = 0.
- R3: A first-level entry with bit 0 (present) clear ends the walk with `rsp_code` = 1 and no second-level read.
- R4: A second-level entry with bit 0 clear ends the walk with `rsp_code` = 2.
- R5: A write request (`req_write` = 1) through an entry whose bit 1 (writable) is clear, at either level, faults with `rsp_code` = 3.
- R6: A user request (`req_user` = 1) through an entry whose bit 2 (user) is clear, at either level, faults with `rsp_code` = 4; at one level the present check comes first, then the user check, then the write check.
- R7: On a fault, `fault_addr` takes the request's linear address; it changes at no other time and reads 0 after reset.
- R8: A request accepted while `paging_on` = 0 returns `rsp_phys` equal to `req_addr`, no fault, and issues no memory read.
- R9: At most one memory read is outstanding; each level issues exactly one read; `req_ready` is 1 only in `ST_IDLE`.
- R10: After reset `req_ready` = 1, `rsp_valid` = 0, `mem_rd_valid` = 0 and `fault_addr` = 0.
- R11: `rsp_valid` is a single-cycle pulse per accepted request, whatever the memory latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_on | input | 1 | Translation enable, sampled when a request is accepted |
| dir_base | input | 32 | First-level table base, 4 KB aligned in bits 31:12 |
| req_valid | input | 1 | Translation request |
| req_ready | output | 1 | Walker idle and accepting |
| req_addr | input | 32 | Linear address to translate |
| req_write | input | 1 | Request is a write |
| req_user | input | 1 | Request comes from user privilege |
| mem_rd_valid | output | 1 | One-cycle memory read request |
| mem_rd_addr | output | 32 | Entry address to read |
| mem_rsp_valid | input | 1 | Read data is valid |
| mem_rsp_data | input | 32 | Entry read from memory |
| rsp_valid | output | 1 | Result pulse |
| rsp_fault | output | 1 | Result is a fault |
| rsp_code | output | 3 | 0 none, 1 first level absent, 2 second level absent, 3 write denied, 4 user denied |
| rsp_phys | output | 32 | Physical address (0 on fault) |
| fault_addr | output | 32 | Linear address of the latest fault |

## Verification
The assertions assume the memory answers each read exactly once, only after the read was requested, and that `dir_base` and the table contents stay fixed while a walk is under way. The bench keeps to this with a memory model that holds one pending read, answers it after one to four cycles chosen per request, and loads every table before the first request. Requests are offered only when `req_ready` is seen high, so the acceptance cycle, and with it the sampled `paging_on`, is unambiguous.

// File: rtl/pw_pkg.sv
package pw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DIR,
        ST_TBL,
        ST_DONE,
        ST_FAULT
    } walk_st_e;

    typedef enum logic [2:0] {
        FLT_NONE       = 3'd0,
        FLT_DIR_ABSENT = 3'd1,
        FLT_TBL_ABSENT = 3'd2,
        FLT_WRITE      = 3'd3,
        FLT_USER       = 3'd4
    } flt_e;

    // flag bit positions inside a translation entry
    localparam int unsigned ENT_PRESENT = 0;
    localparam int unsigned ENT_WRITE   = 1;
    localparam int unsigned ENT_USER    = 2;
    localparam int unsigned ENT_FLAGS   = 3;

endpackage

// File: rtl/pw_entry_addr.sv
module pw_entry_addr #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12,
    parameter int unsigned IDX_W  = 10
) (
    input  logic [ADDR_W-OFF_W-1:0] frame,
    input  logic [IDX_W-1:0]        idx,
    output logic [ADDR_W-1:0]       addr
);
    // each entry is four bytes wide
    localparam int unsigned SLOT_W = IDX_W + 2;

    logic [SLOT_W-1:0] slot;

    assign slot = {idx, 2'b00};
    assign addr = {frame, OFF_W'(slot)};
endmodule

// File: rtl/pw_perm_check.sv
module pw_perm_check
    import pw_pkg::*;
#(
    parameter flt_e ABSENT_CODE = FLT_DIR_ABSENT
) (
    input  logic [ENT_FLAGS-1:0] flags,
    input  logic                 is_write,
    input  logic                 is_user,
    output flt_e                 code
);
    always_comb begin
        if (!flags[ENT_PRESENT])
            code = ABSENT_CODE;
        else if (is_user && !flags[ENT_USER])
            code = FLT_USER;
        else if (is_write && !flags[ENT_WRITE])
            code = FLT_WRITE;
        else
            code = FLT_NONE;
    end
endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import pw_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              paging_on,
    input  logic [ADDR_W-1:0] dir_base,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic              req_user,
    output logic              mem_rd_valid,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_code,
    output logic [ADDR_W-1:0] rsp_phys,
    output logic [ADDR_W-1:0] fault_addr
);
    localparam int unsigned FRM_W  = ADDR_W - OFF_W;
    localparam int unsigned IDX_W  = FRM_W / 2;
    localparam int unsigned LEVELS = 2;

    walk_st_e          state_q, state_d;
    logic [ADDR_W-1:0] va_q;
    logic              wr_q;
    logic              usr_q;
    logic              sent_q;
    logic [FRM_W-1:0]  tbl_frame_q;
    logic [ADDR_W-1:0] phys_q;
    flt_e              code_q;
    logic [ADDR_W-1:0] fault_addr_q;

    logic [FRM_W-1:0]  lvl_frame [LEVELS];
    logic [IDX_W-1:0]  lvl_idx   [LEVELS];
    logic [ADDR_W-1:0] lvl_addr  [LEVELS];
    flt_e              lvl_code  [LEVELS];

    logic unused_bits;
    assign unused_bits = ^{dir_base[OFF_W-1:0], mem_rsp_data[OFF_W-1:ENT_FLAGS]};

    // level 0 indexes the directory with the top field, level 1 the table
    assign lvl_frame[0] = dir_base[ADDR_W-1:OFF_W];
    assign lvl_idx[0]   = va_q[ADDR_W-1 -: IDX_W];
    assign lvl_frame[1] = tbl_frame_q;
    assign lvl_idx[1]   = va_q[OFF_W +: IDX_W];

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_lvl
        pw_entry_addr #(
            .ADDR_W (ADDR_W),
            .OFF_W  (OFF_W),
            .IDX_W  (IDX_W)
        ) u_addr (
            .frame (lvl_frame[lv]),
            .idx   (lvl_idx[lv]),
            .addr  (lvl_addr[lv])
        );

        pw_perm_check #(
            .ABSENT_CODE ((lv == 0) ? FLT_DIR_ABSENT : FLT_TBL_ABSENT)
        ) u_chk (
            .flags    (mem_rsp_data[ENT_FLAGS-1:0]),
            .is_write (wr_q),
            .is_user  (usr_q),
            .code     (lvl_code[lv])
        );
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid)
                    state_d = paging_on ? ST_DIR : ST_DONE;
            end
            ST_DIR: begin
                if (mem_rsp_valid)
                    state_d = (lvl_code[0] != FLT_NONE) ? ST_FAULT : ST_TBL;
            end
            ST_TBL: begin
                if (mem_rsp_valid)
                    state_d = (lvl_code[1] != FLT_NONE) ? ST_FAULT : ST_DONE;
            end
            ST_DONE:  state_d = ST_IDLE;
            ST_FAULT: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // walk datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            va_q         <= '0;
            wr_q         <= 1'b0;
            usr_q        <= 1'b0;
            sent_q       <= 1'b0;
            tbl_frame_q  <= '0;
            phys_q       <= '0;
            code_q       <= FLT_NONE;
            fault_addr_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        va_q   <= req_addr;
                        wr_q   <= req_write;
                        usr_q  <= req_user;
                        sent_q <= 1'b0;
                        code_q <= FLT_NONE;
                        phys_q <= req_addr;
                    end
                end
                ST_DIR: begin
                    if (mem_rd_valid)
                        sent_q <= 1'b1;
                    if (mem_rsp_valid) begin
                        sent_q <= 1'b0;
                        if (lvl_code[0] != FLT_NONE) begin
                            code_q       <= lvl_code[0];
                            fault_addr_q <= va_q;
                        end else begin
                            tbl_frame_q <= mem_rsp_data[ADDR_W-1:OFF_W];
                        end
                    end
                end
                ST_TBL: begin
                    if (mem_rd_valid)
                        sent_q <= 1'b1;
                    if (mem_rsp_valid) begin
                        sent_q <= 1'b0;
                        if (lvl_code[1] != FLT_NONE) begin
                            code_q       <= lvl_code[1];
                            fault_addr_q <= va_q;
                        end else begin
                            phys_q <= {mem_rsp_data[ADDR_W-1:OFF_W], va_q[OFF_W-1:0]};
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready    = 1'b0;
        mem_rd_valid = 1'b0;
        mem_rd_addr  = '0;
        rsp_valid    = 1'b0;
        rsp_fault    = 1'b0;
        rsp_code     = FLT_NONE;
        rsp_phys     = '0;
        unique case (state_q)
            ST_IDLE: req_ready = 1'b1;
            ST_DIR: begin
                mem_rd_valid = !sent_q;
                mem_rd_addr  = lvl_addr[0];
            end
            ST_TBL: begin
                mem_rd_valid = !sent_q;
                mem_rd_addr  = lvl_addr[1];
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
                rsp_phys  = phys_q;
            end
            ST_FAULT: begin
                rsp_valid = 1'b1;
                rsp_fault = 1'b1;
                rsp_code  = code_q;
            end
            default: ;
        endcase
    end

    assign fault_addr = fault_addr_q;

    // ---------------- assertions ----------------
    logic rd_pend_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_pend_q <= 1'b0;
        else if (mem_rsp_valid)
            rd_pend_q <= 1'b0;
        else if (mem_rd_valid)
            rd_pend_q <= 1'b1;
    end

    p_one_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> !rd_pend_q);

    p_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid || mem_rd_valid) |-> !req_ready);

    p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_fa_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(fault_addr) |-> (rsp_valid && rsp_fault));

    p_fa_value_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (fault_addr == va_q));

    p_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_phys[OFF_W-1:0] == va_q[OFF_W-1:0]));

    p_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_valid |-> (mem_rd_addr[1:0] == 2'b00));

    p_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_code != 3'd0)));

endmodule

// File: tb/xlate_walker_tb.sv
`timescale 1ns/1ps
module xlate_walker_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_on = 1'b1;
    logic [31:0] dir_base = 32'h0010_0000;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        mem_rd_valid;
    logic [31:0] mem_rd_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [2:0]  rsp_code;
    logic [31:0] rsp_phys;
    logic [31:0] fault_addr;

    always #4 clk = ~clk;

    xlate_walker u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .paging_on     (paging_on),
        .dir_base      (dir_base),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_addr      (req_addr),
        .req_write     (req_write),
        .req_user      (req_user),
        .mem_rd_valid  (mem_rd_valid),
        .mem_rd_addr   (mem_rd_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_fault     (rsp_fault),
        .rsp_code      (rsp_code),
        .rsp_phys      (rsp_phys),
        .fault_addr    (fault_addr)
    );

    typedef struct {
        logic [31:0] phys;
        logic [2:0]  code;
        logic [31:0] fa;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] rd_q[$];
    string       rd_tag_q[$];
    logic [31:0] mem [logic [31:0]];
    logic [31:0] exp_fa = '0;
    int          checks = 0;
    int          fails = 0;
    int          lat = 1;
    int          cycles = 0;
    bit          done = 0;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem.exists(a)) return mem[a];
        return 32'h0;
    endfunction

    function automatic logic [31:0] mkva(input int d, input int t, input int o);
        return {d[9:0], t[9:0], o[11:0]};
    endfunction

    // entry flag check in spec order: present, user, write
    function automatic logic [2:0] perm(input logic [31:0] e, input bit wr, input bit usr, input logic [2:0] absent);
        if (!e[0]) return absent;
        if (usr && !e[2]) return 3'd4;
        if (wr && !e[1]) return 3'd3;
        return 3'd0;
    endfunction

    // driver: builds expectation from the requirements, then offers the request
    task automatic issue(input logic [31:0] va, input bit wr, input bit usr, input bit pg, input string tag);
        exp_t e;
        logic [31:0] a1, a2, e1, e2;
        e.tag = tag;
        e.phys = '0;
        e.code = 3'd0;
        if (!pg) begin
            e.phys = va;                                   // R8
        end else begin
            a1 = {dir_base[31:12], va[31:22], 2'b00};      // R1
            rd_q.push_back(a1); rd_tag_q.push_back({tag, " R1 dir"});
            e1 = rd(a1);
            e.code = perm(e1, wr, usr, 3'd1);
            if (e.code == 3'd0) begin
                a2 = {e1[31:12], va[21:12], 2'b00};        // R1
                rd_q.push_back(a2); rd_tag_q.push_back({tag, " R1 tbl"});
                e2 = rd(a2);
                e.code = perm(e2, wr, usr, 3'd2);
                if (e.code == 3'd0) e.phys = {e2[31:12], va[11:0]};  // R2
            end
            if (e.code != 3'd0) exp_fa = va;               // R7
        end
        e.fa = exp_fa;
        exp_q.push_back(e);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        paging_on = pg;
        req_addr  = va;
        req_write = wr;
        req_user  = usr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = (lat % 4) + 1;
    endtask

    // memory model: one pending read, answered after lat cycles
    bit          pend = 0;
    int          cnt = 0;
    logic [31:0] pend_addr = '0;
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (pend) begin
            if (cnt <= 1) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend_addr);
                pend = 0;
            end else begin
                cnt--;
            end
        end
        if (rst_n && mem_rd_valid) begin
            check(!pend, "R9 read while another outstanding", 32'd1, 32'd0);
            if (rd_q.size() == 0) begin
                check(0, "R9/R8 unexpected memory read", mem_rd_addr, 32'h0);
            end else begin
                check(mem_rd_addr == rd_q[0], rd_tag_q[0], mem_rd_addr, rd_q[0]);
                void'(rd_q.pop_front());
                void'(rd_tag_q.pop_front());
            end
            pend = 1;
            cnt = lat;
            pend_addr = mem_rd_addr;
        end
    end

    // monitor: compares each result pulse with the oldest expectation
    logic last_rsp = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (rsp_valid && last_rsp)
                check(0, "R11 result pulse longer than one cycle", 32'd1, 32'd0);
            if (rsp_valid) begin
                check(!req_ready, "R9 ready during result", {31'd0, req_ready}, 32'd0);
                if (exp_q.size() == 0) begin
                    check(0, "R11 result without request", rsp_phys, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(rsp_code == e.code, {e.tag, " code"}, {29'd0, rsp_code}, {29'd0, e.code});
                    check(rsp_fault == (e.code != 3'd0), {e.tag, " fault flag"}, {31'd0, rsp_fault}, {31'd0, e.code != 3'd0});
                    if (e.code == 3'd0)
                        check(rsp_phys == e.phys, {e.tag, " phys"}, rsp_phys, e.phys);
                    check(fault_addr == e.fa, {e.tag, " R7 fault_addr"}, fault_addr, e.fa);
                end
            end
        end
        last_rsp = rsp_valid;
    end

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                fails++;
                checks++;
                $display("FAIL watchdog expired actual=%0d expected=<100000", cycles);
                finish_run();
            end
        end
    end

    initial begin
        // directory at 0x0010_0000
        mem[32'h0010_0000 + 0*4]    = 32'h0020_0007;  // rw user
        mem[32'h0010_0000 + 1*4]    = 32'h0000_0000;  // absent
        mem[32'h0010_0000 + 2*4]    = 32'h0020_1005;  // read-only user
        mem[32'h0010_0000 + 3*4]    = 32'h0020_2003;  // rw supervisor
        mem[32'h0010_0000 + 1023*4] = 32'h0020_3027;  // rw user, accessed
        // tables
        mem[32'h0020_0000 + 0*4]    = 32'hABCD_E007;
        mem[32'h0020_0000 + 1*4]    = 32'h1234_5006;  // absent
        mem[32'h0020_0000 + 2*4]    = 32'h1234_5005;  // read-only user
        mem[32'h0020_0000 + 3*4]    = 32'h5432_1003;  // supervisor only
        mem[32'h0020_1000]          = 32'h1111_1007;
        mem[32'h0020_2000]          = 32'h2222_2007;
        mem[32'h0020_3000 + 1023*4] = 32'hFFFF_F007;

        repeat (3) @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10 req_ready", {31'd0, req_ready}, 32'd1);
        check(rsp_valid == 1'b0, "R10 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        check(mem_rd_valid == 1'b0, "R10 mem_rd_valid", {31'd0, mem_rd_valid}, 32'd0);
        check(fault_addr == 32'h0, "R10 fault_addr", fault_addr, 32'h0);
        rst_n = 1'b1;

        issue(mkva(0, 0, 12'h123), 0, 1, 1, "R2 user read");
        issue(mkva(0, 0, 12'hFFF), 1, 0, 1, "R2 supervisor write");
        issue(mkva(1, 0, 12'h010), 0, 0, 1, "R3 dir absent");
        issue(mkva(0, 1, 12'h020), 0, 0, 1, "R4 table absent");
        issue(mkva(0, 2, 12'h030), 1, 1, 1, "R5 table read-only write");
        issue(mkva(0, 2, 12'h034), 0, 1, 1, "R5 table read-only read");
        issue(mkva(2, 0, 12'h040), 1, 1, 1, "R5 dir read-only write");
        issue(mkva(2, 0, 12'h044), 0, 1, 1, "R5 dir read-only read");
        issue(mkva(0, 3, 12'h050), 0, 1, 1, "R6 table supervisor user read");
        issue(mkva(0, 3, 12'h054), 1, 0, 1, "R6 table supervisor access");
        issue(mkva(3, 0, 12'h060), 0, 1, 1, "R6 dir supervisor user read");
        issue(mkva(3, 0, 12'h064), 1, 1, 1, "R6 user before write priority");
        issue(32'hDEAD_BEEF,       1, 1, 0, "R8 passthrough");
        issue(32'h0000_0000,       0, 0, 0, "R8 passthrough zero");
        issue(mkva(1023, 1023, 12'hABC), 1, 1, 1, "R1 top indices");
        issue(mkva(3, 0, 12'h068), 0, 0, 1, "R2 supervisor through dir");

        while (exp_q.size() != 0) @(negedge clk);
        repeat (6) @(negedge clk);
        check(rd_q.size() == 0, "R9 all expected reads issued", rd_q.size(), 32'd0);
        check(req_ready == 1'b1, "R9 idle after last walk", {31'd0, req_ready}, 32'd1);
        done = 1;
        finish_run();
    end

endmodule